// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads one table entry per level from a three-level radix page table in memory. A requester presents the virtual address together with the physical base of the top-level table. The walker then issues up to three read requests, one at a time, over a valid/ready memory port. Responses come back on a separate valid-only port. When the walk ends, the block presents either the translated physical address or a fault for exactly one cycle.

Each table entry is 64 bits wide. Bit 0 is the valid flag. Bits 53..10 hold a 44-bit frame number. The base of the next table is that frame number shifted left by 12. The leaf frame number, joined with the page offset, forms the result. Only one translation is in flight at any time. Requests, caching and permission handling are left to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: A request whose virtual address has any of bits 63..39 set completes with res_fault=1 and res_level=3 in the cycle after acceptance, and it makes no memory read.
- R2: The first read goes to the level-2 entry at address req_root + 8 × vaddr[38:30].
- R3: After a valid level-2 entry, the second read goes to (entry[53:10] << 12) + 8 × vaddr[29:21]. Bit 0 of an entry is its valid flag.
- R4: After a valid level-1 entry, the third read goes to (entry[53:10] << 12) + 8 × vaddr[20:12].
- R5: A successful walk makes exactly three reads, in level order 2, then 1, then 0.
- R6: On success, res_paddr equals {level-0 entry[53:10], vaddr[11:0]} and res_fault=0.
- R7: An entry with bit 0 clear at level L ends the walk with res_fault=1 and res_level=L. No further read is issued.
- R8: req_ready is high only while the walker is idle. It falls in the cycle after acceptance and returns in the cycle after the single-cycle res_valid pulse.
- R9: While mem_req_ready is low, mem_req_valid stays high and mem_req_addr holds its value.
- R10: After reset, req_ready=1, mem_req_valid=0 and res_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, able to accept a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | PA_W | Physical base of the level-2 table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | PTE_W | Entry contents |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Translation failed |
| res_level | output | 2 | Level of the invalid entry, 3 for an out-of-range address |
| res_paddr | output | PA_W | Translated physical address (zero on fault) |

## Verification
Some properties are checked by assertions on every cycle. These cover the range fault that completes one cycle after acceptance, an invalid entry that ends the walk at once and reports its level, the single-cycle result pulse, the ready drop after acceptance, and a stalled read that stays stable. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural memory. That covers the entry addresses built from the indices and from the frame numbers of earlier entries, the strict 2-1-0 read order and count, and the final address built from the leaf frame and the offset. The bench runs these scenarios both with and without backpressure on the read port.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W    = 56,
  parameter int PTE_W   = 64,
  parameter int PPN_LSB = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [63:0]      req_vaddr,
  input  logic [PA_W-1:0]  req_root,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             res_valid,
  output logic             res_fault,
  output logic [1:0]       res_level,
  output logic [PA_W-1:0]  res_paddr
);
  localparam int PPN_W = PA_W - 12;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_DONE} st_t;

  st_t              st;
  logic [1:0]       lvl;
  logic [26:0]      vpn;
  logic [11:0]      off;
  logic [PA_W-1:0]  base;
  logic [PPN_W-1:0] leaf;
  logic             fault;
  logic [1:0]       flvl;
  logic [8:0]       idx;
  logic [PPN_W-1:0] ppn;
  logic             unused_ok;

  assign ppn       = mem_rsp_data[PPN_LSB +: PPN_W];
  assign unused_ok = ^mem_rsp_data;
  assign idx       = (lvl == 2'd2) ? vpn[26:18] : (lvl == 2'd1) ? vpn[17:9] : vpn[8:0];

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = base + {{(PA_W-12){1'b0}}, idx, 3'b000};
  assign res_valid     = (st == S_DONE);
  assign res_fault     = fault;
  assign res_level     = flvl;
  assign res_paddr     = fault ? '0 : {leaf, off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      lvl   <= 2'd0;
      vpn   <= '0;
      off   <= '0;
      base  <= '0;
      leaf  <= '0;
      fault <= 1'b0;
      flvl  <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          vpn   <= req_vaddr[38:12];
          off   <= req_vaddr[11:0];
          base  <= req_root;
          lvl   <= 2'd2;
          fault <= 1'b0;
          flvl  <= 2'd0;
          if (|req_vaddr[63:39]) begin
            fault <= 1'b1;
            flvl  <= 2'd3;
            st    <= S_DONE;
          end else begin
            st <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) st <= S_RSP;
        S_RSP: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            fault <= 1'b1;
            flvl  <= lvl;
            st    <= S_DONE;
          end else if (lvl == 2'd0) begin
            leaf <= ppn;
            st   <= S_DONE;
          end else begin
            base <= {ppn, 12'b0};
            lvl  <= lvl - 2'd1;
            st   <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_range_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_vaddr[63:39] != '0))
      |=> (res_valid && res_fault && res_level == 2'd3 && !mem_req_valid));

  assert_invalid_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RSP && mem_rsp_valid && !mem_rsp_data[0])
      |=> (res_valid && res_fault && res_level == $past(lvl) && !mem_req_valid));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && req_ready));

  assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  localparam int PA_W = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [63:0] req_vaddr = '0;
  logic [PA_W-1:0] req_root = '0;
  logic mem_req_valid, mem_req_ready;
  logic [PA_W-1:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic res_valid, res_fault;
  logic [1:0] res_level;
  logic [PA_W-1:0] res_paddr;

  int checks = 0;
  int errors = 0;
  logic slow = 1'b0;
  logic tick;
  logic [63:0] mem [4096];
  logic [PA_W-1:0] log_a [64];
  int nreads;

  always #4 clk = ~clk;

  pt_walker #(.PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_fault(res_fault), .res_level(res_level),
    .res_paddr(res_paddr));

  assign mem_req_ready = !slow || tick;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      tick          <= 1'b0;
      nreads        <= 0;
    end else begin
      tick          <= ~tick;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid     <= 1'b1;
        mem_rsp_data      <= mem[mem_req_addr[14:3]];
        log_a[nreads % 64] <= mem_req_addr;
        nreads            <= nreads + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pte(input logic [43:0] ppn, input bit v);
    return ({20'b0, ppn} << 10) | {63'b0, v};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = '0;
  endtask

  task automatic issue_and_wait(input logic [63:0] va, input logic [PA_W-1:0] root);
    @(negedge clk);
    req_vaddr = va;
    req_root  = root;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int w = 0; w < 200 && !res_valid; w++) @(negedge clk);
    chk(res_valid, "R8 result arrives", {63'b0, res_valid}, 64'd1);
    chk(!req_ready, "R8 ready low during result", {63'b0, req_ready}, 64'd0);
  endtask

  task automatic after_result();
    @(negedge clk);
    chk(!res_valid && req_ready, "R8 pulse ends and ready returns",
        {62'b0, res_valid, req_ready}, 64'd1);
  endtask

  // bad_lvl: 0..2 marks that level invalid, 3 = full valid chain
  task automatic walk(input logic [8:0] i2, input logic [8:0] i1, input logic [8:0] i0,
                      input logic [11:0] o, input int rpg, input int p1, input int p0,
                      input logic [43:0] leaf, input int bad_lvl, input bit use_slow);
    logic [63:0] va;
    logic [PA_W-1:0] e [3];
    int n0, exp_n;
    clear_mem();
    slow = use_slow;
    va = {25'b0, i2, i1, i0, o};
    e[0] = PA_W'(rpg) * 4096 + PA_W'(i2) * 8;
    e[1] = PA_W'(p1) * 4096 + PA_W'(i1) * 8;
    e[2] = PA_W'(p0) * 4096 + PA_W'(i0) * 8;
    mem[e[0][14:3]] = pte(44'(p1), bad_lvl != 2);
    mem[e[1][14:3]] = pte(44'(p0), bad_lvl != 1);
    mem[e[2][14:3]] = pte(leaf, bad_lvl != 0);
    n0 = nreads;
    issue_and_wait(va, PA_W'(rpg) * 4096);
    exp_n = (bad_lvl == 3) ? 3 : 3 - bad_lvl;
    chk(nreads - n0 == exp_n, (bad_lvl == 3) ? "R5 read count" : "R7 no reads after invalid",
        64'(nreads - n0), 64'(exp_n));
    chk(log_a[n0 % 64] == e[0], "R2 level-2 entry address", 64'(log_a[n0 % 64]), 64'(e[0]));
    if (exp_n > 1)
      chk(log_a[(n0 + 1) % 64] == e[1], "R3 level-1 entry address",
          64'(log_a[(n0 + 1) % 64]), 64'(e[1]));
    if (exp_n > 2)
      chk(log_a[(n0 + 2) % 64] == e[2], "R4 level-0 entry address",
          64'(log_a[(n0 + 2) % 64]), 64'(e[2]));
    if (bad_lvl == 3) begin
      chk(!res_fault && res_paddr == {leaf, o}, "R6 physical address",
          64'(res_paddr), 64'({leaf, o}));
    end else begin
      chk(res_fault && res_level == 2'(bad_lvl), "R7 fault level",
          {62'b0, res_level} | (64'(res_fault) << 8), 64'(bad_lvl) | 64'h100);
    end
    after_result();
    slow = 1'b0;
  endtask

  task automatic range_fault(input logic [63:0] va);
    int n0;
    n0 = nreads;
    issue_and_wait(va, 56'h1000);
    chk(res_fault && res_level == 2'd3, "R1 range fault",
        {62'b0, res_level} | (64'(res_fault) << 8), 64'h103);
    chk(nreads == n0, "R1 no memory read", 64'(nreads - n0), 64'd0);
    after_result();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !res_valid, "R10 reset state",
        {61'b0, req_ready, mem_req_valid, res_valid}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    walk(9'd5, 9'h1ff, 9'd0, 12'habc, 1, 2, 3, 44'hfed_cba9_8765, 3, 1'b0);
    walk(9'h1ff, 9'd0, 9'h1ff, 12'h000, 4, 7, 6, 44'h1, 3, 1'b1);
    walk(9'd0, 9'd17, 9'd300, 12'hfff, 2, 5, 1, 44'hfff_ffff_ffff, 3, 1'b0);
    walk(9'd9, 9'd8, 9'd7, 12'h123, 1, 2, 3, 44'h42, 2, 1'b0);
    walk(9'd9, 9'd8, 9'd7, 12'h123, 1, 2, 3, 44'h42, 1, 1'b1);
    walk(9'd9, 9'd8, 9'd7, 12'h123, 1, 2, 3, 44'h42, 0, 1'b0);
    range_fault(64'h0000_0080_0000_0000);
    range_fault(64'h8000_0000_0000_1234);
    walk(9'd1, 9'd2, 9'd3, 12'h456, 3, 3, 3, 44'h777, 3, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule